// File: doc/BRIEF.md
# BCH Syndrome Substitution Unit

This unit sits behind a hardware BCH remainder engine in a flash-memory error correction path. For one sector it takes the compressed partial-syndrome words the remainder engine leaves behind and expands them into the complete set of 2t syndromes over GF(2^m). The error-locator solver downstream reads these syndromes. The field is GF(2^13) for 512-byte sectors and GF(2^14) for 1024-byte sectors.

A one-cycle start pulse captures the field mode, a 3-bit strength index and every partial-syndrome word. The unit then runs an iterative datapath that uses a bit-serial GF multiplier with polynomial reduction, so it needs no log or antilog tables. It first evaluates every odd syndrome by Horner's rule at alpha^i. It then squares earlier syndromes to produce the even ones. A one-cycle done pulse marks the point at which the whole syndrome array is valid. The array keeps its value until the next accepted start.

Top module: `syn_subst`

## Requirements
- R1: A start pulse while idle captures sector1024, strengthIdx and partialWords. While a computation runs, changes on these inputs and further start pulses have no effect on the results.
- R2: strengthIdx selects t. The values 0, 1, 2, 3, 4 and 5 give t = 2, 4, 8, 12, 24 and 32. The values 6 and 7 also give t = 32.
- R3: Partial entry n lies in bits [16n+15:16n] of partialWords. This places it in word n/2, with odd n in the upper half and even n in the lower half. Entry n belongs to syndrome index 2n+1. Only its bits 0..m-1 are used, with m = 13 when sector1024 is 0 and m = 14 when it is 1.
- R4: For odd i up to 2t-1, S_i is the XOR of alpha^(i*j) over every set bit j of the entry's partial value. Alpha is the root x of the polynomial 0x201b (m = 13) or 0x4443 (m = 14), and exponents wrap modulo 2^m - 1.
- R5: For j = 1..t, S_2j equals S_j squared in the selected field, so a zero S_j gives a zero S_2j.
- R6: S_k appears in bits [14k-1:14(k-1)] of syndromes. Every slot above 2t reads zero after a computation. All of syndromes is zero after reset.
- R7: done goes high for exactly one cycle once all 2t syndromes are valid. syndromes then holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a sector |
| sector1024 | input | 1 | 0: GF(2^13), 1: GF(2^14) |
| strengthIdx | input | 3 | Correction strength selector |
| partialWords | input | 512 | Sixteen 32-bit words holding two partial entries each |
| syndromes | output | 896 | S_1..S_64, 14 bits per slot |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that start is a single-cycle pulse. They also assume that partial entries used in GF(2^13) mode may carry stray bits above bit 12, and those bits must be ignored. The squaring and empty-slot properties hold for any captured strength, including the two indices that clamp to 32. The stimulus keeps start one cycle wide and issues it only from the idle state, except in one test that pulses start and changes every input in the middle of a run. Random words fill all sixteen bits of every entry, so the GF(2^13) runs also exercise the ignored upper bits.

// File: rtl/syn_pkg.sv
package syn_pkg;
  localparam int SYN_MAX_T = 32;
  localparam int GF_W      = 14;
  localparam int PART_W    = 16;
  localparam int SLOT_N    = 2 * SYN_MAX_T;
  localparam int SLOT_W    = $clog2(SLOT_N);
  localparam int ENTRY_W   = $clog2(SYN_MAX_T);
  localparam int BIT_W     = $clog2(PART_W);
  localparam int T_W       = $clog2(SYN_MAX_T + 1);
  localparam int WORD_N    = SYN_MAX_T / 2;
  localparam int IN_W      = WORD_N * 32;
  localparam logic [GF_W:0] POLY_NARROW = 15'h201b;
  localparam logic [GF_W:0] POLY_WIDE   = 15'h4443;

  typedef struct packed {
    logic                capture;
    logic                loadOdd;
    logic                firstOdd;
    logic                loadEven;
    logic [SLOT_W-1:0]   evenSrc;
    logic                step;
    logic                last;
    logic                useBit;
    logic [BIT_W-1:0]    mulSel;
    logic [BIT_W-1:0]    bitSel;
    logic [ENTRY_W-1:0]  entrySel;
    logic                store;
    logic [SLOT_W-1:0]   storeSlot;
  } dpCtrl_t;

  function automatic logic [GF_W-1:0] gfXtime(input logic [GF_W-1:0] x, input logic wide);
    logic [GF_W:0] y;
    y = {x, 1'b0};
    if (wide) begin
      if (y[GF_W]) y = y ^ POLY_WIDE;
    end else if (y[GF_W-1]) begin
      y = y ^ POLY_NARROW;
    end
    return y[GF_W-1:0];
  endfunction

  function automatic logic [T_W-1:0] strengthOf(input logic [2:0] idx);
    int t;
    case (idx)
      3'd0: t = 2;
      3'd1: t = 4;
      3'd2: t = 8;
      3'd3: t = 12;
      3'd4: t = 24;
      default: t = 32;
    endcase
    if (t > SYN_MAX_T) t = SYN_MAX_T;
    return T_W'(t);
  endfunction
endpackage

// File: rtl/syn_datapath.sv
module syn_datapath
  import syn_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctl,
  input  logic                   wide,
  input  logic [IN_W-1:0]        partialIn,
  output logic [SLOT_N*GF_W-1:0] synFlat
);
  logic [IN_W-1:0] partialReg;
  logic [GF_W-1:0] syn [SLOT_N];
  logic [GF_W-1:0] opA, opB, prod, stepVal;
  logic [ENTRY_W+BIT_W-1:0] bitPos;
  logic bitVal;

  assign bitPos  = {ctl.entrySel, ctl.bitSel};
  assign bitVal  = ctl.useBit & partialReg[bitPos];
  assign stepVal = gfXtime(prod, wide) ^ (opB[ctl.mulSel] ? opA : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      partialReg <= '0;
      opA <= '0;
      opB <= '0;
      prod <= '0;
      for (int k = 0; k < SLOT_N; k++) syn[k] <= '0;
    end else begin
      if (ctl.capture) begin
        partialReg <= partialIn;
        for (int k = 0; k < SLOT_N; k++) syn[k] <= '0;
      end
      if (ctl.loadOdd) begin
        opA  <= '0;
        prod <= '0;
        opB  <= ctl.firstOdd ? GF_W'(2) : gfXtime(gfXtime(opB, wide), wide);
      end
      if (ctl.loadEven) begin
        opA  <= syn[ctl.evenSrc];
        opB  <= syn[ctl.evenSrc];
        prod <= '0;
      end
      if (ctl.step) begin
        if (ctl.last) begin
          opA  <= stepVal ^ GF_W'(bitVal);
          prod <= '0;
        end else begin
          prod <= stepVal;
        end
      end
      if (ctl.store) syn[ctl.storeSlot] <= opA;
    end
  end

  for (genvar g = 0; g < SLOT_N; g++) begin : g_out
    assign synFlat[g*GF_W +: GF_W] = syn[g];
  end
endmodule

// File: rtl/syn_ctrl.sv
module syn_ctrl
  import syn_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           sector1024,
  input  logic [2:0]     strengthIdx,
  output dpCtrl_t        ctl,
  output logic           busy,
  output logic           done,
  output logic           cfgMode,
  output logic [T_W-1:0] cfgT
);
  typedef enum logic [2:0] {
    IDLE, ODD_LOAD, ODD_MUL, ODD_STORE, EVEN_LOAD, EVEN_MUL, EVEN_STORE, FINISH
  } state_t;

  state_t state;
  logic [ENTRY_W-1:0] entryN;
  logic [T_W-1:0]     evenJ;
  logic [BIT_W-1:0]   bitJ, mulK, mTop;
  logic lastEntry, lastEven;

  assign mTop      = cfgMode ? BIT_W'(GF_W - 1) : BIT_W'(GF_W - 2);
  assign lastEntry = (T_W'(entryN) == cfgT - T_W'(1));
  assign lastEven  = (evenJ == cfgT);
  assign busy      = (state != IDLE);
  assign done      = (state == FINISH);

  always_comb begin
    ctl = '0;
    ctl.entrySel = entryN;
    ctl.bitSel   = bitJ;
    ctl.mulSel   = mulK;
    ctl.last     = (mulK == '0);
    ctl.evenSrc  = SLOT_W'(evenJ - T_W'(1));
    case (state)
      IDLE:       ctl.capture = start;
      ODD_LOAD:   begin ctl.loadOdd = 1'b1; ctl.firstOdd = (entryN == '0); end
      ODD_MUL:    begin ctl.step = 1'b1; ctl.useBit = 1'b1; end
      ODD_STORE:  begin ctl.store = 1'b1; ctl.storeSlot = SLOT_W'({entryN, 1'b0}); end
      EVEN_LOAD:  ctl.loadEven = 1'b1;
      EVEN_MUL:   ctl.step = 1'b1;
      EVEN_STORE: begin ctl.store = 1'b1; ctl.storeSlot = SLOT_W'({evenJ, 1'b0} - 1'b1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      cfgMode <= 1'b0;
      cfgT    <= '0;
      entryN  <= '0;
      evenJ   <= '0;
      bitJ    <= '0;
      mulK    <= '0;
    end else begin
      case (state)
        IDLE: if (start) begin
          cfgMode <= sector1024;
          cfgT    <= strengthOf(strengthIdx);
          entryN  <= '0;
          state   <= ODD_LOAD;
        end
        ODD_LOAD: begin
          bitJ  <= mTop;
          mulK  <= mTop;
          state <= ODD_MUL;
        end
        ODD_MUL: begin
          if (mulK == '0) begin
            if (bitJ == '0) state <= ODD_STORE;
            else begin
              bitJ <= bitJ - 1'b1;
              mulK <= mTop;
            end
          end else mulK <= mulK - 1'b1;
        end
        ODD_STORE: begin
          if (lastEntry) begin
            evenJ <= T_W'(1);
            state <= EVEN_LOAD;
          end else begin
            entryN <= entryN + 1'b1;
            state  <= ODD_LOAD;
          end
        end
        EVEN_LOAD: begin
          mulK  <= mTop;
          state <= EVEN_MUL;
        end
        EVEN_MUL: begin
          if (mulK == '0) state <= EVEN_STORE;
          else mulK <= mulK - 1'b1;
        end
        EVEN_STORE: begin
          if (lastEven) state <= FINISH;
          else begin
            evenJ <= evenJ + 1'b1;
            state <= EVEN_LOAD;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/syn_subst.sv
module syn_subst
  import syn_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   sector1024,
  input  logic [2:0]             strengthIdx,
  input  logic [IN_W-1:0]        partialWords,
  output logic [SLOT_N*GF_W-1:0] syndromes,
  output logic                   done
);
  dpCtrl_t        ctl;
  logic           busy;
  logic           cfgMode;
  logic [T_W-1:0] cfgT;

  syn_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sector1024(sector1024),
    .strengthIdx(strengthIdx), .ctl(ctl), .busy(busy), .done(done),
    .cfgMode(cfgMode), .cfgT(cfgT)
  );

  syn_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wide(cfgMode),
    .partialIn(partialWords), .synFlat(syndromes)
  );
endmodule

// File: rtl/syn_subst_chk.sv
module syn_subst_chk
  import syn_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   done,
  input logic [SLOT_N*GF_W-1:0] syndromes,
  input logic                   busy,
  input logic                   cfgMode,
  input logic [T_W-1:0]         cfgT
);
  function automatic logic [GF_W-1:0] chkSquare(input logic [GF_W-1:0] a, input logic wide);
    logic [GF_W-1:0] r, b;
    r = '0;
    b = a;
    for (int k = 0; k < GF_W; k++) begin
      if (a[k]) r = r ^ b;
      b = gfXtime(b, wide);
    end
    return r;
  endfunction

  logic upperZero;
  always_comb begin
    upperZero = 1'b1;
    for (int k = 0; k < SLOT_N; k++)
      if (k >= 2 * int'(cfgT) && syndromes[k*GF_W +: GF_W] != '0) upperZero = 1'b0;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(syndromes));

  assert_cfg_locked_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(cfgT) && $stable(cfgMode)));

  assert_s2_square_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (syndromes[GF_W +: GF_W] == chkSquare(syndromes[0 +: GF_W], cfgMode)));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> upperZero);
endmodule

bind syn_subst syn_subst_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .syndromes(syndromes),
  .busy(busy), .cfgMode(cfgMode), .cfgT(cfgT)
);

// File: tb/tb_syn_subst.sv
module tb_syn_subst;
  localparam int MAXT = 32;
  localparam int NSLOT = 2 * MAXT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic sector1024 = 1'b0;
  logic [2:0] strengthIdx = 3'd0;
  logic [511:0] partialWords = '0;
  logic [NSLOT*14-1:0] syndromes;
  logic done;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  logic [13:0] expS [1:NSLOT];

  always #10 clk = ~clk;

  syn_subst dut (
    .clk(clk), .rstN(rstN), .start(start), .sector1024(sector1024),
    .strengthIdx(strengthIdx), .partialWords(partialWords),
    .syndromes(syndromes), .done(done)
  );

  function automatic logic [13:0] bx(input logic [13:0] x, input bit w);
    logic [14:0] y;
    y = {x, 1'b0};
    if (w && y[14]) y = y ^ 15'h4443;
    if (!w && y[13]) y = y ^ 15'h201b;
    return y[13:0];
  endfunction

  function automatic logic [13:0] bmul(input logic [13:0] a, input logic [13:0] b, input bit w);
    logic [13:0] r, s;
    r = '0;
    s = a;
    for (int k = 0; k < 14; k++) begin
      if (b[k]) r = r ^ s;
      s = bx(s, w);
    end
    return r;
  endfunction

  function automatic logic [13:0] bpow(input int e, input bit w);
    logic [13:0] r;
    r = 14'd1;
    for (int k = 0; k < e; k++) r = bx(r, w);
    return r;
  endfunction

  function automatic int tOf(input logic [2:0] idx);
    case (idx)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic model(input bit w, input logic [2:0] idx, input logic [511:0] words);
    int t, m;
    logic [15:0] val;
    logic [13:0] s;
    t = tOf(idx);
    m = w ? 14 : 13;
    for (int k = 1; k <= NSLOT; k++) expS[k] = '0;
    for (int n = 0; n < t; n++) begin
      val = words[16*n +: 16];
      s = '0;
      for (int j = 0; j < m; j++)
        if (val[j]) s = s ^ bpow((2*n+1)*j, w);
      expS[2*n+1] = s;
    end
    for (int j = 1; j <= t; j++) expS[2*j] = bmul(expS[j], expS[j], w);
  endtask

  task automatic check(input bit ok, input string tag, input logic [13:0] act, input logic [13:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runCase(input bit w, input logic [2:0] idx, input logic [511:0] words,
                         input string tag, input bit disturb);
    int cnt;
    int t;
    string slotTag;
    t = tOf(idx);
    model(w, idx, words);
    @(negedge clk);
    sector1024 = w;
    strengthIdx = idx;
    partialWords = words;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    if (disturb) begin
      repeat (40) @(negedge clk);
      partialWords = ~words;
      sector1024 = ~w;
      strengthIdx = 3'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && cnt < 20000) begin
      @(negedge clk);
      cnt++;
    end
    check(done === 1'b1, {tag, " R7 done seen"}, 14'(done), 14'd1);
    for (int k = 1; k <= NSLOT; k++) begin
      if (k > 2*t) slotTag = "R6 upper slot";
      else if (k % 2 == 1) slotTag = "R4 odd syndrome";
      else slotTag = "R5 even syndrome";
      check(syndromes[(k-1)*14 +: 14] === expS[k],
            $sformatf("%s %s S%0d", tag, slotTag, k), syndromes[(k-1)*14 +: 14], expS[k]);
    end
    @(negedge clk);
    check(done === 1'b0, {tag, " R7 done single cycle"}, 14'(done), 14'd0);
    repeat (3) @(negedge clk);
    check(syndromes[0 +: 14] === expS[1], {tag, " R7 hold after done"}, syndromes[0 +: 14], expS[1]);
  endtask

  function automatic logic [511:0] randWords();
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom();
    return r;
  endfunction

  initial begin
    logic [511:0] w;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done === 1'b0, "R7 reset done", 14'(done), 14'd0);
    check(syndromes === '0, "R6 reset syndromes", syndromes[13:0], 14'd0);

    runCase(1'b0, 3'd0, '0, "R4 zero input", 1'b0);

    w = '0;
    w[16] = 1'b1;
    w[33] = 1'b1;
    runCase(1'b0, 3'd1, w, "R3 packing", 1'b0);

    w = '0;
    for (int n = 0; n < 32; n++) w[16*n] = 1'b1;
    runCase(1'b1, 3'd2, w, "R4 unit entries", 1'b0);

    w = '0;
    for (int n = 0; n < 32; n++) w[16*n +: 16] = 16'he000;
    runCase(1'b0, 3'd5, w, "R3 upper bits ignored", 1'b0);

    runCase(1'b0, 3'd3, randWords(), "R4 random t12", 1'b0);
    runCase(1'b1, 3'd4, randWords(), "R4 random t24", 1'b0);
    runCase(1'b1, 3'd5, randWords(), "R5 random t32", 1'b0);
    runCase(1'b0, 3'd7, randWords(), "R2 index7", 1'b0);
    runCase(1'b1, 3'd6, randWords(), "R2 index6", 1'b0);
    runCase(1'b1, 3'd0, randWords(), "R6 small after large", 1'b0);
    runCase(1'b0, 3'd1, randWords(), "R1 busy disturb", 1'b1);
    runCase(1'b1, 3'd1, randWords(), "R4 random t4", 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog R7 actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule